// File: doc/BRIEF.md
# Bit-Plane Section Shift Adder

This block is the digital model of one section of a bit-serial in-memory multiply-accumulate array. It receives one bit-slice of eight unsigned input activations per cycle. The section has four groups. Each group holds sixteen stored weight columns of eight bits each. Each group selects one of its columns and ANDs that column with the input slice. It counts the matching ones and clips the count to a 3-bit code. The four codes are then combined with binary weighting: the group index is the bit position of the weight bit that group stores. The result is one 9-bit partial sum for that slice.

A write port loads the weight store one column at a time. A write is accepted only in a cycle with no compute request. The partial sum is registered one cycle after the request, with a valid flag. While no request is presented, the sum holds its last value. Several sections can share the same input slice and compute different kernels; surrounding logic shifts and accumulates partial sums across slices.

Top module: `bitplane_section_adder`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_sum` is 0, and every stored weight bit is 0.
- R2: A request (`in_valid` high at a rising edge) produces `out_valid` high after exactly that one edge. A cycle without a request produces `out_valid` low after that edge.
- R3: The count of group g is the number of rows r for which `in_bits[r]` and stored bit r of the selected column of group g are both 1.
- R4: A group count of 8 is clipped to 7. Counts 0 to 7 pass unchanged.
- R5: `out_sum` is the sum over g = 0..3 of (count of group g) shifted left by g. Its largest value is 105.
- R6: Group g uses the column whose index is `col_sel[4g+3:4g]`.
- R7: A cycle without a request leaves `out_sum` unchanged.
- R8: A write presented together with a request is dropped, and the stored weights stay unchanged.
- R9: A write with `in_valid` low stores `wr_data` into column `wr_col` of group `wr_group`. Bit r of `wr_data` is the weight for row r.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Weight column write request |
| wr_group | input | 2 | Group addressed by the write |
| wr_col | input | 4 | Column addressed within the group |
| wr_data | input | 8 | Column weight bits, bit r for row r |
| in_valid | input | 1 | Compute request for this cycle |
| in_bits | input | 8 | Input activation bit-slice, one bit per row |
| col_sel | input | 16 | Column index per group, group g in bits [4g+3:4g] |
| out_valid | output | 1 | Partial sum is new this cycle |
| out_sum | output | 9 | Registered partial sum |

## Verification
The bench drives an all-ones slice against an all-ones column. A design without the clip would wrap the code to 0 or spill a carry into the next weight position. The bench loads distinct patterns in every group and varies the selectors, which exposes a swapped shift or a wrong selector field because the sum moves by a power of two. It issues a write in the same cycle as a request and later reads that column back through a compute, so a design that lets the write through returns the new pattern. Idle gaps between requests catch a design that keeps asserting valid or lets the sum drift.

// File: rtl/bps_pkg.sv
package bps_pkg;

  // Number of set bits in a vector of up to 64 bits.
  function automatic int unsigned ones_in(input logic [63:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 64; i++) begin
      n += int'(v[i]);
    end
    return n;
  endfunction

  // Clamp a count to the largest code a narrow converter can express.
  function automatic int unsigned clip_to(input int unsigned cnt, input int unsigned top);
    return (cnt > top) ? top : cnt;
  endfunction

endpackage

// File: rtl/bps_weight_store.sv
module bps_weight_store #(
  parameter int ROWS   = 8,
  parameter int GROUPS = 4,
  parameter int COLS   = 16,
  parameter int IDX_W  = 4,
  parameter int GRP_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_commit,
  input  logic [GRP_W-1:0]        wr_group,
  input  logic [IDX_W-1:0]        wr_col,
  input  logic [ROWS-1:0]         wr_data,
  input  logic [GROUPS*IDX_W-1:0] col_sel,
  output logic [GROUPS*ROWS-1:0]  rd_cols
);
  localparam int ADDR_W = GRP_W + IDX_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [ROWS-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) begin
        mem_q[a] <= '0;
      end
    end else if (wr_commit) begin
      mem_q[{wr_group, wr_col}] <= wr_data;
    end
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_rd
    localparam logic [GRP_W-1:0] GID = GRP_W'(g);
    logic [ADDR_W-1:0] rd_addr;
    assign rd_addr = {GID, col_sel[g*IDX_W +: IDX_W]};
    assign rd_cols[g*ROWS +: ROWS] = mem_q[rd_addr];
  end
endmodule

// File: rtl/bps_group_count.sv
module bps_group_count #(
  parameter int ROWS  = 8,
  parameter int CNT_W = 3
) (
  input  logic [ROWS-1:0]  in_bits,
  input  logic [ROWS-1:0]  wcol,
  output logic [CNT_W-1:0] cnt
);
  import bps_pkg::*;
  localparam int unsigned CODE_MAX = (1 << CNT_W) - 1;

  logic [63:0] prod_wide;

  always_comb begin
    prod_wide = '0;
    prod_wide[ROWS-1:0] = in_bits & wcol;
    cnt = CNT_W'(clip_to(ones_in(prod_wide), CODE_MAX));
  end
endmodule

// File: rtl/bps_shift_accum.sv
module bps_shift_accum #(
  parameter int GROUPS = 4,
  parameter int CNT_W  = 3,
  parameter int OUT_W  = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [GROUPS*CNT_W-1:0] cnt_flat,
  output logic                    out_valid,
  output logic [OUT_W-1:0]        out_sum
);
  logic [OUT_W-1:0] sum_d;

  always_comb begin
    sum_d = '0;
    for (int g = 0; g < GROUPS; g++) begin
      sum_d = sum_d + (OUT_W'(cnt_flat[g*CNT_W +: CNT_W]) << g);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sum <= sum_d;
      end
    end
  end
endmodule

// File: rtl/bitplane_section_adder.sv
module bitplane_section_adder #(
  parameter int ROWS   = 8,
  parameter int GROUPS = 4,
  parameter int COLS   = 16,
  parameter int CNT_W  = 3,
  parameter int OUT_W  = 9
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [$clog2(GROUPS)-1:0]     wr_group,
  input  logic [$clog2(COLS)-1:0]       wr_col,
  input  logic [ROWS-1:0]               wr_data,
  input  logic                          in_valid,
  input  logic [ROWS-1:0]               in_bits,
  input  logic [GROUPS*$clog2(COLS)-1:0] col_sel,
  output logic                          out_valid,
  output logic [OUT_W-1:0]              out_sum
);
  localparam int IDX_W = $clog2(COLS);
  localparam int GRP_W = $clog2(GROUPS);

  // Named internal events for the checker.
  logic                    wr_commit;
  logic [GROUPS*ROWS-1:0]  sel_cols;
  logic [GROUPS*CNT_W-1:0] grp_cnt;

  assign wr_commit = wr_en & ~in_valid;

  bps_weight_store #(
    .ROWS(ROWS), .GROUPS(GROUPS), .COLS(COLS), .IDX_W(IDX_W), .GRP_W(GRP_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_commit(wr_commit), .wr_group(wr_group),
    .wr_col(wr_col), .wr_data(wr_data), .col_sel(col_sel), .rd_cols(sel_cols)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    bps_group_count #(.ROWS(ROWS), .CNT_W(CNT_W)) u_cnt (
      .in_bits(in_bits),
      .wcol(sel_cols[g*ROWS +: ROWS]),
      .cnt(grp_cnt[g*CNT_W +: CNT_W])
    );
  end

  bps_shift_accum #(.GROUPS(GROUPS), .CNT_W(CNT_W), .OUT_W(OUT_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cnt_flat(grp_cnt),
    .out_valid(out_valid), .out_sum(out_sum)
  );
endmodule

// File: rtl/bps_section_chk.sv
module bps_section_chk #(
  parameter int ROWS   = 8,
  parameter int GROUPS = 4,
  parameter int CNT_W  = 3,
  parameter int OUT_W  = 9
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic                    in_valid,
  input logic [ROWS-1:0]         in_bits,
  input logic                    wr_commit,
  input logic [GROUPS*CNT_W-1:0] grp_cnt,
  input logic                    out_valid,
  input logic [OUT_W-1:0]        out_sum
);
  localparam int MAX_SUM = ((1 << CNT_W) - 1) * ((1 << GROUPS) - 1);

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  idle_novalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R7
  hold_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_sum));

  // R8
  no_write_in_compute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_valid) |-> !wr_commit);

  // R5
  sum_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_sum) <= MAX_SUM));

  for (genvar g = 0; g < GROUPS; g++) begin : g_c
    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (int'(grp_cnt[g*CNT_W +: CNT_W]) <= $countones(in_bits)));
  end
endmodule

bind bitplane_section_adder bps_section_chk #(
  .ROWS(ROWS), .GROUPS(GROUPS), .CNT_W(CNT_W), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .in_valid(in_valid),
  .in_bits(in_bits), .wr_commit(wr_commit), .grp_cnt(grp_cnt),
  .out_valid(out_valid), .out_sum(out_sum)
);

// File: tb/bitplane_section_adder_tb.sv
module bitplane_section_adder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_group = '0;
  logic [3:0] wr_col = '0;
  logic [7:0] wr_data = '0;
  logic       in_valid = 1'b0;
  logic [7:0] in_bits = '0;
  logic [15:0] col_sel = '0;
  logic       out_valid;
  logic [8:0] out_sum;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] model [4][16];
  int exp_q[$];
  string tag_q[$];
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  bitplane_section_adder u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_group(wr_group),
    .wr_col(wr_col), .wr_data(wr_data), .in_valid(in_valid),
    .in_bits(in_bits), .col_sel(col_sel), .out_valid(out_valid),
    .out_sum(out_sum)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected partial sum, restated with counts kept as separate terms.
  function automatic int expect_sum(input logic [7:0] bits, input logic [15:0] sel);
    int total = 0;
    for (int g = 0; g < 4; g++) begin
      int c = 0;
      logic [7:0] w = model[g][sel[g*4 +: 4]];
      for (int r = 0; r < 8; r++) if (bits[r] && w[r]) c++;
      if (c == 8) c = 7;
      total += c * (1 << g);
    end
    return total;
  endfunction

  task automatic write_col(input int g, input int c, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_group = 2'(g); wr_col = 4'(c); wr_data = d;
    model[g][c] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Driver: one request, expected result pushed to the scoreboard.
  task automatic drive(input logic [7:0] bits, input logic [15:0] sel, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_bits = bits; col_sel = sel;
    exp_q.push_back(expect_sum(bits, sel));
    tag_q.push_back(req);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: compare each valid result with the oldest expectation.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected valid", 1, 0);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, int'(out_sum), e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int g = 0; g < 4; g++)
      for (int c = 0; c < 16; c++) model[g][c] = '0;
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 out_sum", int'(out_sum), 0);
    rst_n = 1'b1;
    // R1 weights cleared: all-ones slice yields 0
    drive(8'hFF, 16'h9A53, "R1 cleared weights");

    // R9 load every column with a pattern
    for (int g = 0; g < 4; g++)
      for (int c = 0; c < 16; c++)
        write_col(g, c, 8'((g * 53 + c * 29 + 7) ^ (c << 3)));

    // R4 saturation: all-ones column in every group -> 7*15 = 105
    for (int g = 0; g < 4; g++) write_col(g, 5, 8'hFF);
    drive(8'hFF, 16'h5555, "R4 saturate all groups");
    @(negedge clk);
    check("R4 R5 max sum", int'(out_sum), 105);
    // R4 seven ones pass unchanged: 7*15 = 105 also; use single group
    drive(8'h7F, 16'h0005, "R4 seven ones group0");

    // R5 weight position of each group in isolation
    for (int g = 0; g < 4; g++) begin
      logic [15:0] s;
      s = 16'h0000 | (16'h5 << (g * 4));
      write_col(0, 0, 8'h00); write_col(1, 0, 8'h00);
      write_col(2, 0, 8'h00); write_col(3, 0, 8'h00);
      drive(8'h03, s, $sformatf("R5 group%0d shift", g));
    end

    // R6 selector field per group
    write_col(2, 9, 8'h0F);
    write_col(2, 10, 8'hF0);
    drive(8'h0F, 16'h0900, "R6 group2 col9");
    drive(8'h0F, 16'h0A00, "R6 group2 col10");

    // R7 idle gap: sum holds, valid low
    drive(8'hA5, 16'h1234, "R3 pattern before idle");
    @(negedge clk);
    begin
      int held;
      held = int'(out_sum);
      repeat (3) @(negedge clk);
      check("R7 hold sum", int'(out_sum), held);
      check("R2 idle valid low", int'(out_valid), 0);
    end

    // R8 write during compute is dropped
    write_col(1, 7, 8'h00);
    @(negedge clk);
    in_valid = 1'b1; in_bits = 8'h00; col_sel = 16'h0000;
    wr_en = 1'b1; wr_group = 2'd1; wr_col = 4'd7; wr_data = 8'hFF;
    exp_q.push_back(expect_sum(8'h00, 16'h0000));
    tag_q.push_back("R8 compute with write");
    @(negedge clk);
    in_valid = 1'b0; wr_en = 1'b0;
    write_col(0, 0, 8'h00); write_col(2, 0, 8'h00); write_col(3, 0, 8'h00);
    drive(8'hFF, 16'h0070, "R8 column unchanged");

    // R3 back-to-back pseudo-random patterns
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      in_valid = 1'b1; in_bits = lfsr[7:0]; col_sel = {lfsr[3:0], lfsr[15:4]};
      exp_q.push_back(expect_sum(in_bits, col_sel));
      tag_q.push_back("R3 R5 random stream");
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 all results seen", exp_q.size(), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule